// File: doc/BRIEF.md
# System Address Decoder with Interleaving

This block classifies each physical request address and selects the destination node for it. Four rule tables check the address in parallel. A legacy table covers fine-grained special windows. A configuration-space window interleaves across up to eight nodes. DRAM windows interleave across 1, 2, 4 or 8 nodes. MMIO windows each send their range to a single node. When more than one table matches, a fixed priority picks the result: legacy first, then the configuration-space window, then DRAM, then MMIO. An address that matches no table is aborted. Within one table, the matching entry with the lowest index wins.

The response comes out one clock after the request and carries a valid strobe. It gives the request class, the target node and an abort flag. For an aborted read, the response data is all ones. For an aborted write, the data is discarded and the write is not committed. The rule tables are loaded through a simple write port. Each table entry has a base word, a limit word and an attribute word.

Top module: `sys_addr_decode`

## Requirements
- R1: A write on the programming port loads one rule word. Address bits [7:6] select the table: 0 legacy, 1 configuration window, 2 DRAM, 3 MMIO. Bits [5:2] select the entry and bits [1:0] select the word: 0 base, 1 limit, 2 attribute. Word 3 is ignored. In the attribute word, bit 0 is the enable, bits [3:1] are the legacy class code, and bits [6:4] are the single target for legacy and MMIO entries. For the configuration window and DRAM entries, bits [2:1] are the log2 of the way count and bits [31:8] hold eight 3-bit node IDs, with way k at bits [8+3k+2:8+3k].
- R2: A legacy hit takes precedence over every other table. The class is the entry's code, where codes 0 home, 1 config, 2 trusted, 3 MMIO and 4 IO are passed through and codes 5 to 7 mean abort. The target is the entry's target field. Legacy base and limit are in 4 KB units.
- R3: With no legacy hit, a configuration-window hit gives class 1. The target is the node ID at way (address bits [22:20] masked to the way count).
- R4: With no legacy or configuration-window hit, a DRAM hit gives class 0 (home). The target is the node ID at way (address bits [8:6] masked to the way count).
- R5: Otherwise, an MMIO hit gives class 3 with the entry's single target. Configuration-window, DRAM and MMIO bounds are in 16 MB units.
- R6: An address that matches no enabled entry gives class 5 (abort). Every abort response reports target 0 and raises the abort flag.
- R7: When several entries of one table match, the entry with the lowest index decides the result.
- R8: An aborted read returns all-ones data, and an aborted write is not committed. A non-aborted read returns zero data, and a non-aborted write is committed.
- R9: A request presented in one cycle produces its response in the next cycle with the response valid high. With no request, the response valid stays low.
- R10: After reset, every entry is disabled and the response valid is low.
- R11: Both bounds are inclusive. An entry whose enable bit is clear never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Rule word write strobe |
| cfg_addr | input | 8 | Rule word select (table, entry, word) |
| cfg_wdata | input | 32 | Rule word value |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | Request is a write |
| req_addr | input | 40 | Request physical address |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_class | output | 3 | Request class code |
| rsp_target | output | 3 | Selected node ID |
| rsp_abort | output | 1 | Request aborted |
| rsp_rdata | output | 64 | Read response data (all ones on abort) |
| rsp_wr_commit | output | 1 | Write accepted for delivery |

## Verification
The assertions take for granted that the rule tables do not change in the cycle a request is decoded. A write on the programming port together with a request could otherwise show a decision made from the old rules against the new hit signals. The stimulus therefore programs rules only while no request is outstanding. It then sends requests, mostly inside the first gigabyte where the random windows overlap densely, so that priority and lowest-index selection come up often. Some requests use fully random addresses to reach the no-match abort.

// File: rtl/sad_pkg.sv
package sad_pkg;
  localparam logic [2:0] CLS_HOME  = 3'd0;
  localparam logic [2:0] CLS_CFG   = 3'd1;
  localparam logic [2:0] CLS_TRUST = 3'd2;
  localparam logic [2:0] CLS_MMIO  = 3'd3;
  localparam logic [2:0] CLS_IO    = 3'd4;
  localparam logic [2:0] CLS_ABORT = 3'd5;

  // inclusive window test on granule numbers
  function automatic logic in_window(input logic [31:0] g, input logic [31:0] lo,
                                     input logic [31:0] hi);
    return (g >= lo) && (g <= hi);
  endfunction

  // way index: selector bits masked to 2^ways_log ways
  function automatic logic [2:0] way_index(input logic [2:0] sel, input logic [1:0] ways_log);
    logic [2:0] mask;
    mask = 3'((4'd1 << ways_log) - 4'd1);
    return sel & mask;
  endfunction

  // node ID for a way out of the 8-entry list
  function automatic logic [2:0] pick_node(input logic [23:0] list, input logic [2:0] way);
    return list[3*way +: 3];
  endfunction

  // legacy codes above IO map to abort
  function automatic logic [2:0] legacy_class(input logic [2:0] code);
    return (code > CLS_IO) ? CLS_ABORT : code;
  endfunction
endpackage

// File: rtl/sad_rule_bank.sv
module sad_rule_bank #(
  parameter int NUM = 4,
  parameter int RW = 16,
  parameter logic [1:0] TID = 2'd0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [RW-1:0] req_gran,
  output logic          hit,
  output logic [31:0]   hit_attr
);
  import sad_pkg::*;

  logic [RW-1:0] base_q [NUM];
  logic [RW-1:0] lim_q  [NUM];
  logic [31:0]   attr_q [NUM];
  logic [NUM-1:0] match;
  logic tbl_sel;
  logic bank_unused;

  assign tbl_sel = wr_en && (wr_addr[7:6] == TID);
  assign bank_unused = ^wr_data;

  for (genvar i = 0; i < NUM; i++) begin : g_entry
    logic ent_sel;
    assign ent_sel = tbl_sel && (wr_addr[5:2] == 4'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[i] <= '0;
        lim_q[i]  <= '0;
        attr_q[i] <= '0;
      end else if (ent_sel) begin
        case (wr_addr[1:0])
          2'd0: base_q[i] <= wr_data[RW-1:0];
          2'd1: lim_q[i]  <= wr_data[RW-1:0];
          2'd2: attr_q[i] <= wr_data;
          default: ;
        endcase
      end
    end
    assign match[i] = attr_q[i][0] &&
                      in_window(32'(req_gran), 32'(base_q[i]), 32'(lim_q[i]));
  end

  always_comb begin
    hit = |match;
    hit_attr = '0;
    for (int k = NUM - 1; k >= 0; k--) begin
      if (match[k]) hit_attr = attr_q[k];
    end
  end
endmodule

// File: rtl/sad_abort_resp.sv
module sad_abort_resp #(
  parameter int DATA_W = 64
) (
  input  logic              is_abort,
  input  logic              is_write,
  output logic [DATA_W-1:0] rdata,
  output logic              wr_commit
);
  assign rdata = (is_abort && !is_write) ? '1 : '0;
  assign wr_commit = is_write && !is_abort;
endmodule

// File: rtl/sys_addr_decode.sv
module sys_addr_decode #(
  parameter int ADDR_W = 40,
  parameter int DATA_W = 64,
  parameter int N_LEG = 4,
  parameter int N_DRAM = 4,
  parameter int N_MMIO = 16,
  parameter int LEG_SHIFT = 12,
  parameter int RNG_SHIFT = 24,
  parameter int DRAM_SEL_LO = 6,
  parameter int CFG_SEL_LO = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [2:0]        rsp_class,
  output logic [2:0]        rsp_target,
  output logic              rsp_abort,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_wr_commit
);
  import sad_pkg::*;

  localparam int LEG_RW = ADDR_W - LEG_SHIFT;
  localparam int RNG_RW = ADDR_W - RNG_SHIFT;

  logic        leg_hit, cfgi_hit, dram_hit, mmio_hit;
  logic [31:0] leg_attr, cfgi_attr, dram_attr, mmio_attr;
  logic [2:0]  dec_class, dec_target;
  logic        dec_abort, dec_commit;
  logic [DATA_W-1:0] dec_rdata;
  logic        top_unused;

  wire [LEG_RW-1:0] leg_gran = req_addr[ADDR_W-1:LEG_SHIFT];
  wire [RNG_RW-1:0] rng_gran = req_addr[ADDR_W-1:RNG_SHIFT];

  assign top_unused = ^{req_addr, leg_attr, cfgi_attr, dram_attr, mmio_attr};

  sad_rule_bank #(.NUM(N_LEG), .RW(LEG_RW), .TID(2'd0)) u_leg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
    .req_gran(leg_gran), .hit(leg_hit), .hit_attr(leg_attr));

  sad_rule_bank #(.NUM(1), .RW(RNG_RW), .TID(2'd1)) u_cfgi (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
    .req_gran(rng_gran), .hit(cfgi_hit), .hit_attr(cfgi_attr));

  sad_rule_bank #(.NUM(N_DRAM), .RW(RNG_RW), .TID(2'd2)) u_dram (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
    .req_gran(rng_gran), .hit(dram_hit), .hit_attr(dram_attr));

  sad_rule_bank #(.NUM(N_MMIO), .RW(RNG_RW), .TID(2'd3)) u_mmio (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
    .req_gran(rng_gran), .hit(mmio_hit), .hit_attr(mmio_attr));

  // fixed priority: legacy > config window > DRAM > MMIO > abort
  always_comb begin
    dec_class  = CLS_ABORT;
    dec_target = 3'd0;
    if (leg_hit) begin
      dec_class  = legacy_class(leg_attr[3:1]);
      dec_target = leg_attr[6:4];
    end else if (cfgi_hit) begin
      dec_class  = CLS_CFG;
      dec_target = pick_node(cfgi_attr[31:8],
                             way_index(req_addr[CFG_SEL_LO +: 3], cfgi_attr[2:1]));
    end else if (dram_hit) begin
      dec_class  = CLS_HOME;
      dec_target = pick_node(dram_attr[31:8],
                             way_index(req_addr[DRAM_SEL_LO +: 3], dram_attr[2:1]));
    end else if (mmio_hit) begin
      dec_class  = CLS_MMIO;
      dec_target = mmio_attr[6:4];
    end
    if (dec_class == CLS_ABORT) dec_target = 3'd0;
  end

  assign dec_abort = (dec_class == CLS_ABORT);

  sad_abort_resp #(.DATA_W(DATA_W)) u_abort (
    .is_abort(dec_abort), .is_write(req_write), .rdata(dec_rdata), .wr_commit(dec_commit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_class     <= CLS_ABORT;
      rsp_target    <= 3'd0;
      rsp_abort     <= 1'b0;
      rsp_rdata     <= '0;
      rsp_wr_commit <= 1'b0;
    end else begin
      rsp_valid     <= req_valid;
      rsp_class     <= dec_class;
      rsp_target    <= dec_target;
      rsp_abort     <= dec_abort && req_valid;
      rsp_rdata     <= req_valid ? dec_rdata : '0;
      rsp_wr_commit <= dec_commit && req_valid;
    end
  end
endmodule

// File: rtl/sad_decode_chk.sv
module sad_decode_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic              leg_hit,
  input logic              cfgi_hit,
  input logic              dram_hit,
  input logic              mmio_hit,
  input logic              rsp_valid,
  input logic [2:0]        rsp_class,
  input logic              rsp_abort,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_wr_commit
);
  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R9
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R3
  cfg_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !leg_hit && cfgi_hit) |=> (rsp_class == 3'd1));
  // R4
  dram_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !leg_hit && !cfgi_hit && dram_hit) |=> (rsp_class == 3'd0));
  // R5
  mmio_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !leg_hit && !cfgi_hit && !dram_hit && mmio_hit) |=> (rsp_class == 3'd3));
  // R6
  miss_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !leg_hit && !cfgi_hit && !dram_hit && !mmio_hit) |=> rsp_abort);
  // R8
  abort_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_abort && !$past(req_write)) |-> (rsp_rdata == '1));
  // R8
  abort_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_abort) |-> !rsp_wr_commit);
endmodule

bind sys_addr_decode sad_decode_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .leg_hit(leg_hit), .cfgi_hit(cfgi_hit), .dram_hit(dram_hit), .mmio_hit(mmio_hit),
  .rsp_valid(rsp_valid), .rsp_class(rsp_class), .rsp_abort(rsp_abort),
  .rsp_rdata(rsp_rdata), .rsp_wr_commit(rsp_wr_commit));

// File: tb/sys_addr_decode_tb.sv
`timescale 1ns/1ps
module sys_addr_decode_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [39:0] req_addr = '0;
  logic rsp_valid, rsp_abort, rsp_wr_commit;
  logic [2:0] rsp_class, rsp_target;
  logic [63:0] rsp_rdata;

  int n_chk = 0;
  int n_fail = 0;

  // bench copy of the programmed rules: [table][entry][word]
  logic [31:0] mdl [4][16][3];

  always #10 clk = ~clk;

  sys_addr_decode u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_class(rsp_class), .rsp_target(rsp_target),
    .rsp_abort(rsp_abort), .rsp_rdata(rsp_rdata), .rsp_wr_commit(rsp_wr_commit));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input int tab, input int idx, input int word, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_addr = {tab[1:0], idx[3:0], word[1:0]};
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (word < 3) mdl[tab][idx][word] = d;
  endtask

  task automatic set_rule(input int tab, input int idx, input int b, input int l, input logic [31:0] a);
    reg_wr(tab, idx, 0, b);
    reg_wr(tab, idx, 1, l);
    reg_wr(tab, idx, 2, a);
  endtask

  function automatic int entries(input int tab);
    return (tab == 0) ? 4 : (tab == 1) ? 1 : (tab == 2) ? 4 : 16;
  endfunction

  // expected decision, computed from the requirement text
  task automatic expect_of(input logic [39:0] a, output logic [2:0] cls,
                           output logic [2:0] tgt, output string tag);
    logic [31:0] g;
    int found;
    found = -1;
    cls = 3'd5; tgt = 3'd0; tag = "R6";
    for (int t = 0; t < 4 && found < 0; t++) begin
      g = (t == 0) ? 32'(a >> 12) : 32'(a >> 24);
      for (int i = 0; i < entries(t) && found < 0; i++) begin
        if (mdl[t][i][2][0] && g >= mdl[t][i][0] && g <= mdl[t][i][1]) begin
          found = i;
          if (t == 0) begin
            cls = (mdl[t][i][2][3:1] >= 3'd5) ? 3'd5 : mdl[t][i][2][3:1];
            tgt = mdl[t][i][2][6:4];
            tag = "R2";
          end else if (t == 3) begin
            cls = 3'd3; tgt = mdl[t][i][2][6:4]; tag = "R5";
          end else begin
            int w, nw, sel;
            nw = 1 << mdl[t][i][2][2:1];
            sel = (t == 1) ? int'(a[22:20]) : int'(a[8:6]);
            w = sel % nw;
            tgt = 3'((mdl[t][i][2] >> (8 + 3 * w)) & 32'h7);
            cls = (t == 1) ? 3'd1 : 3'd0;
            tag = (t == 1) ? "R3" : "R4";
          end
        end
      end
    end
    if (cls == 3'd5) tgt = 3'd0;
  endtask

  task automatic do_req(input logic [39:0] a, input logic wr, input string extra);
    logic [2:0] ec, et;
    string tag;
    expect_of(a, ec, et, tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, extra, " R9 valid"}, 64'(rsp_valid), 64'd1);
    check({tag, extra, " class"}, 64'(rsp_class), 64'(ec));
    check({tag, extra, " target"}, 64'(rsp_target), 64'(et));
    check({tag, extra, " R8 abort"}, 64'(rsp_abort), 64'(ec == 3'd5));
    check({tag, extra, " R8 rdata"}, rsp_rdata, (ec == 3'd5 && !wr) ? '1 : 64'd0);
    check({tag, extra, " R8 commit"}, 64'(rsp_wr_commit), 64'(wr && ec != 3'd5));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int t = 0; t < 4; t++)
      for (int i = 0; i < 16; i++)
        for (int w = 0; w < 3; w++) mdl[t][i][w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    check("R10 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    do_req(40'h00_1234_5678, 1'b0, " R10 empty read");
    do_req(40'h00_1234_5678, 1'b1, " R10 empty write");
    // R9 idle: no valid without request
    @(negedge clk);
    check("R9 idle valid", 64'(rsp_valid), 64'd0);

    // R5 / R7 / R11: MMIO overlaps
    set_rule(3, 3, 32'h10, 32'h1F, 32'h51);
    set_rule(3, 1, 32'h18, 32'h20, 32'h21);
    do_req(40'h00_1000_0000, 1'b0, " mmio entry3");
    do_req(40'h00_1800_0000, 1'b0, " R7 lowest index");
    do_req(40'h00_20FF_FFFF, 1'b1, " R11 inclusive limit");
    do_req(40'h00_2100_0000, 1'b0, " R11 above limit");
    // R1 word 3 ignored
    reg_wr(3, 1, 3, 32'h0);
    do_req(40'h00_2000_0000, 1'b0, " R1 word3 ignored");

    // R4 DRAM 4-way, list way k -> node 7-k, over MMIO
    set_rule(2, 0, 32'h0, 32'h1F, 32'h05397705);
    do_req(40'h00_1800_01C0, 1'b0, " R4 4way over mmio");
    do_req(40'h00_0000_0040, 1'b0, " R4 way1");

    // R3 config window 8-way
    set_rule(1, 0, 32'h1E, 32'h1E, {24'hFAC688, 8'h07});
    do_req(40'h00_1E50_0000, 1'b0, " R3 way5");
    do_req(40'h00_1E70_0000, 1'b1, " R3 way7");

    // R2 legacy trusted and abort codes
    set_rule(0, 2, 32'h1E500, 32'h1E500, 32'h65);
    set_rule(0, 0, 32'h1E700, 32'h1E700, 32'h3F);
    do_req(40'h00_1E50_0ABC, 1'b0, " R2 trusted");
    do_req(40'h00_1E70_0000, 1'b0, " R2 code7 abort");
    do_req(40'h00_1E70_0010, 1'b1, " R2 abort write");
    // R11 disabled entry ignored
    reg_wr(0, 2, 2, 32'h64);
    do_req(40'h00_1E50_0ABC, 1'b0, " R11 disabled");

    // random rule sets
    void'($urandom(32'd12345));
    for (int r = 0; r < 40; r++) begin
      for (int t = 0; t < 4; t++) begin
        for (int i = 0; i < entries(t); i++) begin
          int b, l;
          logic [31:0] at;
          if (t == 0) begin
            b = int'($urandom() % 262144);
            l = b + int'($urandom() % 8192);
          end else begin
            b = int'($urandom() % 64);
            l = b + int'($urandom() % 12);
          end
          at = $urandom();
          at[0] = ($urandom() % 4) != 0;
          set_rule(t, i, b, l, at);
        end
      end
      for (int q = 0; q < 10; q++) begin
        logic [39:0] a;
        if ($urandom() % 8 == 0) a = {8'($urandom()), 32'($urandom())};
        else a = {10'd0, 30'($urandom())};
        do_req(a, 1'($urandom()), " random");
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule